// File: doc/BRIEF.md
# SD SPI-Mode Block Transfer Sequencer

The sequencer runs a complete single-block read or write with an SD card in SPI mode. It sits above a byte-exchange SPI master: for every byte slot it requests one exchange, hands over the byte to shift out, and takes the byte shifted in when the master reports completion. The requester starts an operation with a command index, a 32-bit argument and a trailer byte. The trailer byte carries the CRC and the stop bit. The block builds the command frame, polls for the one-byte R1 reply and then moves the 512-byte data block in the requested direction.

A read waits for the start-of-block token and streams the data bytes out on a valid strobe. The two trailing check bytes are dropped. A write sends a start token and pulls 512 bytes from the requester one at a time. It then sends two 0xFF check bytes, checks the card's data-response byte and waits out the busy period. A fourth operation sends only the stop token that ends a multi-block write, then waits while the card is busy. Every operation ends with a one-cycle done pulse and a result code.

Top module: `sd_blk_seq`

## Requirements
- R1: For read and write operations the first six byte slots send 0x40 plus the 6-bit command index, then the argument bytes from most significant to least, then the caller's trailer byte.
- R2: Every slot in which the sequencer waits for a reply sends 0xFF. At most one byte exchange is outstanding at any time.
- R3: The R1 reply is the first polled byte with bit 7 clear. If POLL_LIMIT polled slots bring no such byte, the operation ends with code 1.
- R4: A nonzero R1 reply ends the operation with code 2, and r1_o holds the reply byte.
- R5: A read (op 0) waits for the byte 0xFE, then gives out the next 512 received bytes in order on rd_valid_o/rd_data_o. It then spends two more slots, whose bytes are not given out. If POLL_LIMIT slots pass without 0xFE, the result is code 3.
- R6: A write sends the token 0xFE for op 1 or 0xFC for op 2. It then sends 512 bytes taken from wr_data_i, with wr_take_o marking each byte used, and then two bytes of 0xFF.
- R7: After a write, the first non-0xFF byte is the data response. The write is accepted when its low five bits are 00101; any other value gives code 4. If POLL_LIMIT slots pass with no response, the result is code 6.
- R8: While the card returns 0x00 the sequencer keeps sending 0xFF. The first nonzero byte completes the operation with code 0. If BUSY_LIMIT slots pass with 0x00, the result is code 5.
- R9: Op 3 sends 0xFD and then one 0xFF slot without a command frame, then follows the busy rule of R8.
- R10: done_o is a single-cycle pulse, and err_code_o is valid with it. busy_o is high from the cycle after the start until done. A start_i while busy has no effect.
- R11: After reset the block is idle: busy_o, done_o, xfer_req_o, rd_valid_o and wr_take_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation when idle |
| op_i | input | 2 | 0 read, 1 single write, 2 multi-token write, 3 stop token |
| cmd_idx_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| trailer_i | input | 8 | Final command byte (CRC and stop bit) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one cycle) |
| err_code_o | output | 3 | Result code, valid with done_o |
| r1_o | output | 8 | Last R1 reply captured |
| rd_valid_o | output | 1 | Read data byte valid |
| rd_data_o | output | 8 | Read data byte |
| wr_take_o | output | 1 | wr_data_i is used in this cycle |
| wr_data_i | input | 8 | Write data byte |
| xfer_req_o | output | 1 | Request one byte exchange |
| xfer_tx_o | output | 8 | Byte to send, valid with xfer_req_o |
| xfer_done_i | input | 1 | Exchange finished |
| xfer_rx_i | input | 8 | Received byte, valid with xfer_done_i |

## Verification
The assertions rely on the SPI master raising xfer_done_i only once for each accepted request, and never in the same cycle as that request. The bench's master model always waits one to four cycles before it answers. The properties also expect start_i to arrive only as a single-cycle pulse. The bench drives it that way, and it raises a second start while a read is in progress to show that it is ignored.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;
  typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_WMULTI, OP_STOP} op_e;
  typedef enum logic [2:0] {
    E_NONE, E_R1_TO, E_R1_BAD, E_TOK_TO, E_REJECT, E_BUSY_TO, E_RSP_TO
  } err_e;
  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_R1, S_TOKW, S_RDAT, S_WTOK, S_WDAT, S_WCRC, S_WRSP, S_STUF, S_WBSY
  } st_e;
  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [4:0] RESP_OK    = 5'b00101;
  localparam int unsigned FRAME_LEN = 6;
endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame (
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  input  logic [7:0]  trailer_i,
  input  logic [2:0]  sel_i,
  output logic [7:0]  byte_o
);
  always_comb begin
    unique case (sel_i)
      3'd0:    byte_o = {2'b01, idx_i};
      3'd1:    byte_o = arg_i[31:24];
      3'd2:    byte_o = arg_i[23:16];
      3'd3:    byte_o = arg_i[15:8];
      3'd4:    byte_o = arg_i[7:0];
      3'd5:    byte_o = trailer_i;
      default: byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_blk_seq.sv
module sd_blk_seq
  import sd_seq_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 512,
  parameter int unsigned POLL_LIMIT = 64,
  parameter int unsigned BUSY_LIMIT = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] arg_i,
  input  logic [7:0]  trailer_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  err_code_o,
  output logic [7:0]  r1_o,
  output logic        rd_valid_o,
  output logic [7:0]  rd_data_o,
  output logic        wr_take_o,
  input  logic [7:0]  wr_data_i,
  output logic        xfer_req_o,
  output logic [7:0]  xfer_tx_o,
  input  logic        xfer_done_i,
  input  logic [7:0]  xfer_rx_i
);
  localparam int unsigned CW = $clog2(DATA_BYTES + 2);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_BYTES - 1);
  localparam logic [CW-1:0] LAST_RD   = CW'(DATA_BYTES + 1);

  st_e           state_q;
  op_e           op_q;
  logic [5:0]    idx_q;
  logic [31:0]   arg_q;
  logic [7:0]    trl_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          got, reply_ok, poll_st, poll_last, busy_last;
  logic [7:0]    frame_byte;

  assign got        = pend_q && xfer_done_i;
  assign busy_o     = (state_q != S_IDLE);
  assign xfer_req_o = busy_o && !pend_q;
  assign wr_take_o  = xfer_req_o && (state_q == S_WDAT);
  assign poll_st    = (state_q == S_R1) || (state_q == S_TOKW) || (state_q == S_WRSP);

  always_comb begin
    unique case (state_q)
      S_R1:    reply_ok = !xfer_rx_i[7];
      S_TOKW:  reply_ok = (xfer_rx_i == TOK_SINGLE);
      S_WRSP:  reply_ok = (xfer_rx_i != FILL_BYTE);
      default: reply_ok = 1'b0;
    endcase
  end

  sd_cmd_frame u_frame (
    .idx_i(idx_q), .arg_i(arg_q), .trailer_i(trl_q),
    .sel_i(cnt_q[2:0]), .byte_o(frame_byte)
  );

  sd_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll_tmr (
    .clk_i, .rst_ni,
    .clr_i (!busy_o || (got && reply_ok)),
    .step_i(got && poll_st && !reply_ok),
    .last_o(poll_last)
  );

  sd_poll_timer #(.LIMIT(BUSY_LIMIT)) u_busy_tmr (
    .clk_i, .rst_ni,
    .clr_i (!busy_o),
    .step_i(got && (state_q == S_WBSY) && (xfer_rx_i == 8'h00)),
    .last_o(busy_last)
  );

  always_comb begin
    unique case (state_q)
      S_CMD:   xfer_tx_o = frame_byte;
      S_WTOK:  xfer_tx_o = (op_q == OP_STOP)   ? TOK_STOP :
                           (op_q == OP_WMULTI) ? TOK_MULTI : TOK_SINGLE;
      S_WDAT:  xfer_tx_o = wr_data_i;
      default: xfer_tx_o = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (xfer_req_o)  pend_q <= 1'b1;
    else if (got)         pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_READ;
      idx_q      <= '0;
      arg_q      <= '0;
      trl_q      <= '0;
      cnt_q      <= '0;
      done_o     <= 1'b0;
      err_code_o <= '0;
      r1_o       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          op_q    <= op_e'(op_i);
          idx_q   <= cmd_idx_i;
          arg_q   <= arg_i;
          trl_q   <= trailer_i;
          cnt_q   <= '0;
          state_q <= (op_e'(op_i) == OP_STOP) ? S_WTOK : S_CMD;
        end
      end else if (got) begin
        unique case (state_q)
          S_CMD: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(FRAME_LEN - 1)) state_q <= S_R1;
          end
          S_R1: begin
            if (reply_ok) begin
              r1_o <= xfer_rx_i;
              if (xfer_rx_i != 8'h00) begin
                state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_R1_BAD;
              end else begin
                state_q <= (op_q == OP_READ) ? S_TOKW : S_WTOK;
              end
            end else if (poll_last) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_R1_TO;
            end
          end
          S_TOKW: begin
            if (reply_ok) begin
              state_q <= S_RDAT; cnt_q <= '0;
            end else if (poll_last) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_TOK_TO;
            end
          end
          S_RDAT: begin
            if (cnt_q <= LAST_DATA) begin
              rd_valid_o <= 1'b1;
              rd_data_o  <= xfer_rx_i;
            end
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_RD) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_NONE;
            end
          end
          S_WTOK: begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_STOP) ? S_STUF : S_WDAT;
          end
          S_WDAT: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_DATA) begin
              state_q <= S_WCRC; cnt_q <= '0;
            end
          end
          S_WCRC: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q[0]) state_q <= S_WRSP;
          end
          S_WRSP: begin
            if (reply_ok) begin
              if (xfer_rx_i[4:0] == RESP_OK) state_q <= S_WBSY;
              else begin
                state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_REJECT;
              end
            end else if (poll_last) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_RSP_TO;
            end
          end
          S_STUF: state_q <= S_WBSY;
          S_WBSY: begin
            if (xfer_rx_i != 8'h00) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_NONE;
            end else if (busy_last) begin
              state_q <= S_IDLE; done_o <= 1'b1; err_code_o <= E_BUSY_TO;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_blk_seq_chk.sv
module sd_blk_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_code_o,
  input logic       rd_valid_o,
  input logic       wr_take_o,
  input logic       xfer_req_o,
  input logic       xfer_done_i
);
  a_r2_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);

  a_r11_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!xfer_req_o && !wr_take_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> busy_o);

  a_r6_take_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> xfer_req_o);

  a_r5_valid_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(xfer_done_i));

  a_r10_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_code_o != 3'd7));
endmodule

bind sd_blk_seq sd_blk_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_code_o(err_code_o), .rd_valid_o(rd_valid_o),
  .wr_take_o(wr_take_o), .xfer_req_o(xfer_req_o), .xfer_done_i(xfer_done_i)
);

// File: tb/sd_blk_seq_tb.sv
`timescale 1ns/1ps
module sd_blk_seq_tb;
  localparam int PL = 16;
  localparam int BL = 40;
  localparam int MAXS = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [5:0] idx = '0;
  logic [31:0] arg = '0;
  logic [7:0] trl = '0;
  logic busy, done, rd_valid, wr_take, xreq, xdone;
  logic [2:0] err;
  logic [7:0] r1, rd_data, wr_data, xtx, xrx;

  always #5 clk = ~clk;

  sd_blk_seq #(.DATA_BYTES(512), .POLL_LIMIT(PL), .BUSY_LIMIT(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .cmd_idx_i(idx),
    .arg_i(arg), .trailer_i(trl), .busy_o(busy), .done_o(done), .err_code_o(err),
    .r1_o(r1), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .wr_take_o(wr_take),
    .wr_data_i(wr_data), .xfer_req_o(xreq), .xfer_tx_o(xtx), .xfer_done_i(xdone),
    .xfer_rx_i(xrx)
  );

  logic [7:0] scr [MAXS];
  logic [7:0] exp_tx [MAXS];
  logic [7:0] tx_log [MAXS];
  logic [7:0] rd_log [512];
  logic [7:0] blk [512];
  int scr_len, n_x, n_r, wr_ptr, m_lat;
  logic [7:0] fill = 8'hFF;
  logic m_busy, scen_rst = 1'b0;
  int n_chk = 0, n_fail = 0;

  assign wr_data = blk[wr_ptr % 512];

  // byte-exchange master and card model
  always @(posedge clk) begin
    xdone <= 1'b0;
    if (scen_rst || !rst_n) begin
      n_x <= 0; n_r <= 0; wr_ptr <= 0; m_busy <= 1'b0; m_lat <= 0; xrx <= 8'hFF;
    end else begin
      if (xreq) begin
        m_busy <= 1'b1;
        m_lat  <= int'($urandom % 4);
        if (n_x < MAXS) tx_log[n_x] <= xtx;
      end else if (m_busy) begin
        if (m_lat == 0) begin
          xdone  <= 1'b1;
          xrx    <= (n_x < scr_len) ? scr[n_x] : fill;
          n_x    <= n_x + 1;
          m_busy <= 1'b0;
        end else m_lat <= m_lat - 1;
      end
      if (wr_take) wr_ptr <= wr_ptr + 1;
      if (rd_valid && n_r < 512) begin
        rd_log[n_r] <= rd_data; n_r <= n_r + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] rx, input logic [7:0] tx);
    scr[scr_len] = rx; exp_tx[scr_len] = tx; scr_len++;
  endtask

  task automatic push_frame(input logic [5:0] i, input logic [31:0] a, input logic [7:0] t);
    push(8'hFF, {2'b01, i});
    push(8'hFF, a[31:24]); push(8'hFF, a[23:16]);
    push(8'hFF, a[15:8]);  push(8'hFF, a[7:0]);
    push(8'hFF, t);
  endtask

  task automatic gaps(input int n, input logic [7:0] rx);
    for (int i = 0; i < n; i++) push(rx, 8'hFF);
  endtask

  function automatic logic [7:0] rnd_byte();
    return 8'($urandom);
  endfunction

  task automatic run(input logic [1:0] o, input bit poke, output logic [2:0] e);
    int t;
    @(negedge clk); scen_rst = 1'b1;
    @(negedge clk); scen_rst = 1'b0;
    op = o; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      op = 2'd3; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R10 done reached", t, 0);
    e = err;
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
  endtask

  task automatic cmp_tx(input string req);
    int bad = -1;
    chk(n_x == scr_len, {req, " transfer count"}, n_x, scr_len);
    for (int i = 0; i < scr_len; i++)
      if (bad < 0 && tx_log[i] !== exp_tx[i]) bad = i;
    chk(bad < 0, {req, " sent bytes"}, (bad < 0) ? 0 : tx_log[bad], (bad < 0) ? 0 : exp_tx[bad]);
  endtask

  task automatic do_read(input int k, input int m, input bit poke);
    logic [2:0] e;
    int bad = -1;
    idx = 6'd17; arg = $urandom; trl = rnd_byte(); fill = 8'hFF; scr_len = 0;
    for (int i = 0; i < 512; i++) blk[i] = rnd_byte();
    push_frame(idx, arg, trl);
    gaps(k, 8'hFF); push(8'h00, 8'hFF);
    gaps(m, 8'hFF); push(8'hFE, 8'hFF);
    for (int i = 0; i < 512; i++) push(blk[i], 8'hFF);
    push(rnd_byte(), 8'hFF); push(rnd_byte(), 8'hFF);
    run(2'd0, poke, e);
    chk(e == 3'd0, "R5 read result", e, 0);
    cmp_tx("R1 R2 read");
    chk(n_r == 512, "R5 read byte count", n_r, 512);
    for (int i = 0; i < 512; i++) if (bad < 0 && rd_log[i] !== blk[i]) bad = i;
    chk(bad < 0, "R5 read data", (bad < 0) ? 0 : rd_log[bad], (bad < 0) ? 0 : blk[bad]);
  endtask

  task automatic do_write(input logic [1:0] o, input int k, input int j, input int b,
                          input logic [7:0] resp, input logic [2:0] e_exp, input string req);
    logic [2:0] e;
    idx = 6'd24; arg = $urandom; trl = rnd_byte(); fill = 8'hFF; scr_len = 0;
    for (int i = 0; i < 512; i++) blk[i] = rnd_byte();
    push_frame(idx, arg, trl);
    gaps(k, 8'hFF); push(8'h00, 8'hFF);
    push(8'hFF, (o == 2'd2) ? 8'hFC : 8'hFE);
    for (int i = 0; i < 512; i++) push(8'hFF, blk[i]);
    push(8'hFF, 8'hFF); push(8'hFF, 8'hFF);
    gaps(j, 8'hFF); push(resp, 8'hFF);
    if (e_exp == 3'd0) begin gaps(b, 8'h00); push(8'hFF, 8'hFF); end
    if (e_exp == 3'd5) gaps(BL, 8'h00);
    run(o, 1'b0, e);
    chk(e == e_exp, {req, " result"}, e, e_exp);
    cmp_tx(req);
  endtask

  initial begin
    logic [2:0] e;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !xreq && !rd_valid && !wr_take, "R11 reset idle",
        {busy, done, xreq, rd_valid, wr_take}, 0);
    rst_n = 1'b1;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(!busy && !xreq, "R11 idle after reset", {busy, xreq}, 0);

    do_read(2, 3, 1'b1);          // start while busy is ignored (R10)
    for (int r = 0; r < 3; r++) do_read(int'($urandom % 6), int'($urandom % 12), 1'b0);
    do_read(0, 0, 1'b0);
    do_read(PL - 1, PL - 1, 1'b0); // last allowed slots (R3, R5)

    // R4 nonzero R1
    idx = 6'd17; arg = $urandom; trl = 8'h01; fill = 8'hFF; scr_len = 0;
    push_frame(idx, arg, trl); gaps(2, 8'hFF); push(8'h04, 8'hFF);
    run(2'd0, 1'b0, e);
    chk(e == 3'd2, "R4 bad R1 code", e, 2);
    chk(r1 == 8'h04, "R4 R1 captured", r1, 8'h04);
    cmp_tx("R4");

    // R3 R1 timeout
    scr_len = 0; push_frame(idx, arg, trl); gaps(PL, 8'hFF);
    run(2'd0, 1'b0, e);
    chk(e == 3'd1, "R3 R1 timeout code", e, 1);
    cmp_tx("R3");

    // R5 token timeout
    scr_len = 0; push_frame(idx, arg, trl); gaps(1, 8'hFF); push(8'h00, 8'hFF);
    gaps(PL, 8'hFF);
    run(2'd0, 1'b0, e);
    chk(e == 3'd3, "R5 token timeout code", e, 3);
    cmp_tx("R5 token timeout");

    do_write(2'd1, 1, 2, 5, 8'hE5, 3'd0, "R6 R7 R8 single write");
    do_write(2'd2, 0, 0, 0, 8'h05, 3'd0, "R6 multi token write");
    for (int r = 0; r < 2; r++)
      do_write(2'd1, int'($urandom % 5), int'($urandom % 5), int'($urandom % 20),
               {3'($urandom), 5'b00101}, 3'd0, "R8 random write");
    do_write(2'd1, 1, 1, 0, 8'h0B, 3'd4, "R7 rejected write");
    do_write(2'd1, 0, 0, 0, 8'h05, 3'd5, "R8 busy timeout");

    // R7 data response timeout
    idx = 6'd24; scr_len = 0; fill = 8'hFF;
    push_frame(idx, arg, trl); push(8'h00, 8'hFF); push(8'hFF, 8'hFE);
    for (int i = 0; i < 512; i++) push(8'hFF, blk[i]);
    gaps(2, 8'hFF); gaps(PL, 8'hFF);
    run(2'd1, 1'b0, e);
    chk(e == 3'd6, "R7 response timeout code", e, 6);
    cmp_tx("R7 response timeout");

    // R9 stop token
    scr_len = 0; push(8'hFF, 8'hFD); push(8'hFF, 8'hFF); gaps(7, 8'h00); push(8'hFF, 8'hFF);
    run(2'd3, 1'b0, e);
    chk(e == 3'd0, "R9 stop result", e, 0);
    cmp_tx("R9 stop");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule